// File: doc/BRIEF.md
# Interruptible Weighted-Average Accumulator

This block runs the inner loop of a weighted average. Memory holds two byte lists. One list gives the weights and the other gives the values. Starting from two address pointers, the engine reads one weight and one value in each iteration. It adds the weight into a 16-bit sum of weights and adds the unsigned weight-times-value product into a 32-bit sum of products. An 8-bit count sets how many iterations run. The division that turns the two sums into an average is done elsewhere.

Every iteration follows the same eight-cycle schedule, so a long list can hold off an interrupt for only a bounded time. An interrupt request is examined once per iteration, right after the two operand reads. When the request is accepted, a three-cycle exit winds the count and the pointers back to the start of the interrupted iteration and raises a suspended pulse. The count, the pointers and both sums stay visible on the outputs. A later resume request loads that state back through the inputs and continues the loop without clearing the sums. A fresh start clears the sums first.

Top module: `wavg_engine`

## Requirements
- R1: After a start request is accepted while idle (call that cycle 0), no memory read occurs in cycles 1 through 4, and both sums read zero from cycle 4. The first read, of the weight pointer, happens in cycle 5.
- R2: Each iteration reads the weight byte at the weight pointer in its second cycle and the value byte at the value pointer in its third cycle. Each pointer increments by one after its read.
- R3: The count decrements in the first cycle of each iteration and is tested for zero only after the eighth cycle. A count of zero at entry therefore wraps to 255 and runs 256 iterations.
- R4: Each iteration adds the zero-extended weight to the 16-bit sum of weights and adds the unsigned 8x8 product to the 32-bit sum of products. The low half of the product sum is updated in cycle 7 and the carry into the high half in cycle 8.
- R5: On a normal loop exit, done_o is high for exactly one cycle while busy_o is low, and the outputs hold the final count, pointers and sums. done_o and susp_o are never high together.
- R6: irq_i is examined only at the end of the third cycle of an iteration. When accepted, the next three cycles form an exit sequence, and then susp_o pulses. After the exit, the count and pointers equal their values at the top of the interrupted iteration, and the sums include only completed iterations.
- R7: A resume request accepted while idle loads the count, both pointers, the 32-bit sum and the 16-bit sum from the inputs, and the loop starts in the next cycle. irq_i is not examined during the first iteration after a resume.
- R8: With irq_i held high while busy, susp_o or done_o arrives within 12 cycles, or within 17 cycles when the request comes during the first iteration after a resume.
- R9: start_i and resume_i have no effect while busy_o is high. When both are high while idle, the start wins.
- R10: mem_rd_o is high only in the two read cycles of an iteration, never in three consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Fresh start request; sums are cleared |
| resume_i | input | 1 | Resume request; state loaded from inputs |
| irq_i | input | 1 | Interrupt request, level |
| count_i | input | 8 | Iteration count (0 means 256) |
| wptr_i | input | 16 | Weight list pointer |
| vptr_i | input | 16 | Value list pointer |
| rsum_prod_i | input | 32 | Saved sum of products for resume |
| rsum_wt_i | input | 16 | Saved sum of weights for resume |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory read address |
| mem_data_i | input | 8 | Read data, valid in the strobe cycle |
| busy_o | output | 1 | Engine is running |
| done_o | output | 1 | One-cycle pulse on normal completion |
| susp_o | output | 1 | One-cycle pulse after an interrupt exit |
| count_o | output | 8 | Current iteration count |
| wptr_o | output | 16 | Current weight pointer |
| vptr_o | output | 16 | Current value pointer |
| sum_prod_o | output | 32 | Sum of products |
| sum_wt_o | output | 16 | Sum of weights |

## Verification
The hardest case to reach from the ports is an interrupt that rises just after the sampling point, which gives the worst-case latency. A close second is an interrupt that is already pending when a resume is issued; it must be ignored for one whole iteration and then accepted. The schedule is fixed, so the stimulus counts cycles from the start request and raises irq_i in the cycle where the weight is summed. It then issues a resume with irq_i still high and checks the exact cycle of each suspended pulse. A zero count run over bytes that are all ones covers the count wrap and repeated carries into the high half of the product sum.

// File: rtl/wavg_pkg.sv
package wavg_pkg;

    localparam int ADDR_W_DEF = 16;
    localparam int CNT_W_DEF  = 8;
    localparam int DATA_W_DEF = 8;
    localparam int HALF_W_DEF = 16;
    localparam int MUL_STAGES = 3;
    localparam int LAT_MAX    = 17;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE1,
        ST_PRE2,
        ST_CLR,
        ST_TOP,
        ST_FW,
        ST_FV,
        ST_WSUM,
        ST_MUL0,
        ST_MUL1,
        ST_MUL2,
        ST_CARRY,
        ST_EX1,
        ST_EX2,
        ST_EX3
    } wstate_e;

    typedef struct packed {
        logic load_new;
        logic load_res;
        logic clr;
        logic dec;
        logic fetch_w;
        logic fetch_v;
        logic add_w;
        logic mul0;
        logic mul1;
        logic add_lo;
        logic add_hi;
        logic rew_cnt;
        logic rew_ptr;
    } wctl_t;

    function automatic logic in_loop(input wstate_e s);
        return (s == ST_TOP) || (s == ST_FW) || (s == ST_FV) || (s == ST_WSUM) ||
               (s == ST_MUL0) || (s == ST_MUL1) || (s == ST_MUL2) || (s == ST_CARRY);
    endfunction

endpackage

// File: rtl/wavg_ctrl.sv
module wavg_ctrl
    import wavg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    resume_i,
    input  logic    irq_i,
    input  logic    cnt_zero_i,
    output wstate_e state_o,
    output wctl_t   ctl_o,
    output logic    busy_o,
    output logic    done_o,
    output logic    susp_o
);

    wstate_e st_q, st_d;
    logic    noirq_q;
    logic    done_q, susp_q;
    logic    fin_done, fin_susp;
    wctl_t   ctl;

    always_comb begin
        st_d     = st_q;
        ctl      = '0;
        fin_done = 1'b0;
        fin_susp = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    ctl.load_new = 1'b1;
                    st_d         = ST_PRE1;
                end else if (resume_i) begin
                    ctl.load_res = 1'b1;
                    st_d         = ST_TOP;
                end
            end
            ST_PRE1: st_d = ST_PRE2;
            ST_PRE2: st_d = ST_CLR;
            ST_CLR: begin
                ctl.clr = 1'b1;
                st_d    = ST_TOP;
            end
            ST_TOP: begin
                ctl.dec = 1'b1;
                st_d    = ST_FW;
            end
            ST_FW: begin
                ctl.fetch_w = 1'b1;
                st_d        = ST_FV;
            end
            ST_FV: begin
                ctl.fetch_v = 1'b1;
                st_d        = (irq_i && !noirq_q) ? ST_EX1 : ST_WSUM;
            end
            ST_WSUM: begin
                ctl.add_w = 1'b1;
                st_d      = ST_MUL0;
            end
            ST_MUL0: begin
                ctl.mul0 = 1'b1;
                st_d     = ST_MUL1;
            end
            ST_MUL1: begin
                ctl.mul1 = 1'b1;
                st_d     = ST_MUL2;
            end
            ST_MUL2: begin
                ctl.add_lo = 1'b1;
                st_d       = ST_CARRY;
            end
            ST_CARRY: begin
                ctl.add_hi = 1'b1;
                if (cnt_zero_i) begin
                    fin_done = 1'b1;
                    st_d     = ST_IDLE;
                end else begin
                    st_d = ST_TOP;
                end
            end
            ST_EX1: begin
                ctl.rew_cnt = 1'b1;
                st_d        = ST_EX2;
            end
            ST_EX2: begin
                ctl.rew_ptr = 1'b1;
                st_d        = ST_EX3;
            end
            ST_EX3: begin
                fin_susp = 1'b1;
                st_d     = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            noirq_q <= 1'b0;
            done_q  <= 1'b0;
            susp_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= fin_done;
            susp_q <= fin_susp;
            if (ctl.load_res) begin
                noirq_q <= 1'b1;
            end else if (ctl.load_new || ctl.add_hi) begin
                noirq_q <= 1'b0;
            end
        end
    end

    assign state_o = st_q;
    assign ctl_o   = ctl;
    assign busy_o  = (st_q != ST_IDLE);
    assign done_o  = done_q;
    assign susp_o  = susp_q;

    // R5
    done_susp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_q, susp_q}));

    // R7
    resume_irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FV && noirq_q) |=> (st_q == ST_WSUM));

    // R6
    exit_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(susp_q) |-> $past(st_q == ST_EX3) && !in_loop(st_q));

endmodule

// File: rtl/wavg_addr.sv
module wavg_addr
    import wavg_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  wctl_t             ctl_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] wptr_i,
    input  logic [ADDR_W-1:0] vptr_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] wptr_o,
    output logic [ADDR_W-1:0] vptr_o,
    output logic [DATA_W-1:0] wt_o,
    output logic [DATA_W-1:0] val_o,
    output logic              cnt_zero_o
);

    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] pw_q, pv_q;
    logic [DATA_W-1:0] wt_q, val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pw_q  <= '0;
            pv_q  <= '0;
            wt_q  <= '0;
            val_q <= '0;
        end else begin
            if (ctl_i.load_new || ctl_i.load_res) begin
                cnt_q <= count_i;
                pw_q  <= wptr_i;
                pv_q  <= vptr_i;
            end
            if (ctl_i.dec) begin
                cnt_q <= cnt_q - ONE_C;
            end
            if (ctl_i.rew_cnt) begin
                cnt_q <= cnt_q + ONE_C;
            end
            if (ctl_i.fetch_w) begin
                wt_q <= mem_data_i;
                pw_q <= pw_q + ONE_A;
            end
            if (ctl_i.fetch_v) begin
                val_q <= mem_data_i;
                pv_q  <= pv_q + ONE_A;
            end
            if (ctl_i.rew_ptr) begin
                pw_q <= pw_q - ONE_A;
                pv_q <= pv_q - ONE_A;
            end
        end
    end

    assign mem_rd_o   = ctl_i.fetch_w | ctl_i.fetch_v;
    assign mem_addr_o = ctl_i.fetch_v ? pv_q : pw_q;
    assign count_o    = cnt_q;
    assign wptr_o     = pw_q;
    assign vptr_o     = pv_q;
    assign wt_o       = wt_q;
    assign val_o      = val_q;
    assign cnt_zero_o = (cnt_q == '0);

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_i.fetch_v |-> $past(ctl_i.fetch_w));

    // R10
    read_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && $past(mem_rd_o)) |=> !mem_rd_o);

endmodule

// File: rtl/wavg_mac.sv
module wavg_mac
    import wavg_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  wctl_t               ctl_i,
    input  logic [DATA_W-1:0]   wt_i,
    input  logic [DATA_W-1:0]   val_i,
    input  logic [2*HALF_W-1:0] rsum_prod_i,
    input  logic [HALF_W-1:0]   rsum_wt_i,
    output logic [2*HALF_W-1:0] sum_prod_o,
    output logic [HALF_W-1:0]   sum_wt_o
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int STEP   = (DATA_W + MUL_STAGES - 1) / MUL_STAGES;

    logic [HALF_W-1:0] lo_q, hi_q, sw_q;
    logic [PROD_W-1:0] part_q;
    logic              carry_q;
    logic [HALF_W:0]   lo_sum;
    logic [PROD_W-1:0] prod_full;

    function automatic logic [PROD_W-1:0] pp(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b,
                                             input int k);
        logic [DATA_W-1:0] sl;
        sl = (b >> (k * STEP)) & DATA_W'((1 << STEP) - 1);
        return (PROD_W'(a) * PROD_W'(sl)) << (k * STEP);
    endfunction

    assign prod_full = part_q + pp(wt_i, val_i, MUL_STAGES - 1);
    assign lo_sum    = {1'b0, lo_q} + {1'b0, HALF_W'(prod_full)};

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            hi_q    <= '0;
            sw_q    <= '0;
            part_q  <= '0;
            carry_q <= 1'b0;
        end else begin
            if (ctl_i.clr) begin
                lo_q    <= '0;
                hi_q    <= '0;
                sw_q    <= '0;
                carry_q <= 1'b0;
            end
            if (ctl_i.load_res) begin
                lo_q    <= rsum_prod_i[HALF_W-1:0];
                hi_q    <= rsum_prod_i[2*HALF_W-1:HALF_W];
                sw_q    <= rsum_wt_i;
                carry_q <= 1'b0;
            end
            if (ctl_i.add_w) begin
                sw_q <= sw_q + HALF_W'(wt_i);
            end
            if (ctl_i.mul0) begin
                part_q <= pp(wt_i, val_i, 0);
            end
            if (ctl_i.mul1) begin
                part_q <= part_q + pp(wt_i, val_i, 1);
            end
            if (ctl_i.add_lo) begin
                lo_q    <= lo_sum[HALF_W-1:0];
                carry_q <= lo_sum[HALF_W];
            end
            if (ctl_i.add_hi) begin
                hi_q    <= hi_q + HALF_W'(carry_q);
                carry_q <= 1'b0;
            end
        end
    end

    assign sum_prod_o = {hi_q, lo_q};
    assign sum_wt_o   = sw_q;

    // R4
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.add_hi && !ctl_i.load_res && !ctl_i.clr) |=> $stable(hi_q));

    // R4
    wt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.add_w && !ctl_i.load_res && !ctl_i.clr) |=> $stable(sw_q));

endmodule

// File: rtl/wavg_engine.sv
module wavg_engine
    import wavg_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                resume_i,
    input  logic                irq_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [ADDR_W-1:0]   wptr_i,
    input  logic [ADDR_W-1:0]   vptr_i,
    input  logic [2*HALF_W-1:0] rsum_prod_i,
    input  logic [HALF_W-1:0]   rsum_wt_i,
    output logic                mem_rd_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [DATA_W-1:0]   mem_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                susp_o,
    output logic [CNT_W-1:0]    count_o,
    output logic [ADDR_W-1:0]   wptr_o,
    output logic [ADDR_W-1:0]   vptr_o,
    output logic [2*HALF_W-1:0] sum_prod_o,
    output logic [HALF_W-1:0]   sum_wt_o
);

    localparam int LAT_W = $clog2(LAT_MAX + 2) + 1;

    wstate_e           state;
    wctl_t             ctl;
    logic              cnt_zero;
    logic [DATA_W-1:0] wt, val;
    logic [LAT_W-1:0]  lat_q;

    wavg_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .resume_i   (resume_i),
        .irq_i      (irq_i),
        .cnt_zero_i (cnt_zero),
        .state_o    (state),
        .ctl_o      (ctl),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .susp_o     (susp_o)
    );

    wavg_addr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .count_i    (count_i),
        .wptr_i     (wptr_i),
        .vptr_i     (vptr_i),
        .mem_data_i (mem_data_i),
        .mem_rd_o   (mem_rd_o),
        .mem_addr_o (mem_addr_o),
        .count_o    (count_o),
        .wptr_o     (wptr_o),
        .vptr_o     (vptr_o),
        .wt_o       (wt),
        .val_o      (val),
        .cnt_zero_o (cnt_zero)
    );

    wavg_mac #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) u_mac (
        .clk         (clk),
        .rst         (rst),
        .ctl_i       (ctl),
        .wt_i        (wt),
        .val_i       (val),
        .rsum_prod_i (rsum_prod_i),
        .rsum_wt_i   (rsum_wt_i),
        .sum_prod_o  (sum_prod_o),
        .sum_wt_o    (sum_wt_o)
    );

    always_ff @(posedge clk) begin
        if (rst || !irq_i || !busy_o) begin
            lat_q <= '0;
        end else if (lat_q != '1) begin
            lat_q <= lat_q + LAT_W'(1);
        end
    end

    // R8
    irq_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lat_q <= LAT_W'(LAT_MAX));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && state != ST_CARRY && state != ST_EX3) |=> busy_o);

endmodule

// File: tb/wavg_engine_bench.sv
`timescale 1ns/1ps
module wavg_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, resume_i = 1'b0, irq_i = 1'b0;
    logic [7:0]  count_i = '0;
    logic [15:0] wptr_i = '0, vptr_i = '0;
    logic [31:0] rsum_prod_i = '0;
    logic [15:0] rsum_wt_i = '0;
    logic        mem_rd_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_data_i;
    logic        busy_o, done_o, susp_o;
    logic [7:0]  count_o;
    logic [15:0] wptr_o, vptr_o;
    logic [31:0] sum_prod_o;
    logic [15:0] sum_wt_o;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    int mem_mode = 0;

    always #2 clk = ~clk;

    wavg_engine u_wavg_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .resume_i(resume_i), .irq_i(irq_i),
        .count_i(count_i), .wptr_i(wptr_i), .vptr_i(vptr_i),
        .rsum_prod_i(rsum_prod_i), .rsum_wt_i(rsum_wt_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .busy_o(busy_o), .done_o(done_o), .susp_o(susp_o), .count_o(count_o),
        .wptr_o(wptr_o), .vptr_o(vptr_o), .sum_prod_o(sum_prod_o), .sum_wt_o(sum_wt_o)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        if (mem_mode == 1) return 8'hFF;
        return (a[7:0] * 8'd29) + (a[15:8] * 8'd7) + 8'd3;
    endfunction

    always_comb mem_data_i = mem_byte(mem_addr_o);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // ---- behavioural reference model, one step per clock ----
    int          m_ph = 0;
    logic [7:0]  m_cnt = '0, m_w = '0, m_v = '0;
    logic [15:0] m_pw = '0, m_pv = '0, m_lo = '0, m_hi = '0, m_sw = '0;
    logic        m_c = 1'b0, m_noirq = 1'b0, m_done = 1'b0, m_susp = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        m_done <= 1'b0;
        m_susp <= 1'b0;
        if (rst) begin
            m_ph <= 0; m_cnt <= '0; m_pw <= '0; m_pv <= '0;
            m_lo <= '0; m_hi <= '0; m_sw <= '0; m_c <= 1'b0; m_noirq <= 1'b0;
        end else begin
            case (m_ph)
                0: if (start_i) begin
                       m_cnt <= count_i; m_pw <= wptr_i; m_pv <= vptr_i;
                       m_noirq <= 1'b0; m_ph <= 1;
                   end else if (resume_i) begin
                       m_cnt <= count_i; m_pw <= wptr_i; m_pv <= vptr_i;
                       m_hi <= rsum_prod_i[31:16]; m_lo <= rsum_prod_i[15:0];
                       m_sw <= rsum_wt_i; m_c <= 1'b0; m_noirq <= 1'b1; m_ph <= 11;
                   end
                1: m_ph <= 2;
                2: m_ph <= 3;
                3: begin m_lo <= '0; m_hi <= '0; m_sw <= '0; m_c <= 1'b0; m_ph <= 11; end
                11: begin m_cnt <= m_cnt - 8'd1; m_ph <= 12; end
                12: begin m_w <= mem_byte(m_pw); m_pw <= m_pw + 16'd1; m_ph <= 13; end
                13: begin
                        m_v <= mem_byte(m_pv); m_pv <= m_pv + 16'd1;
                        m_ph <= (irq_i && !m_noirq) ? 21 : 14;
                    end
                14: begin m_sw <= m_sw + {8'd0, m_w}; m_ph <= 15; end
                15: m_ph <= 16;
                16: m_ph <= 17;
                17: begin {m_c, m_lo} <= {1'b0, m_lo} + (17'(m_w) * 17'(m_v)); m_ph <= 18; end
                18: begin
                        m_hi <= m_hi + {15'd0, m_c}; m_c <= 1'b0; m_noirq <= 1'b0;
                        if (m_cnt == 8'd0) begin m_done <= 1'b1; m_ph <= 0; end
                        else m_ph <= 11;
                    end
                21: begin m_cnt <= m_cnt + 8'd1; m_ph <= 22; end
                22: begin m_pw <= m_pw - 16'd1; m_pv <= m_pv - 16'd1; m_ph <= 23; end
                23: begin m_susp <= 1'b1; m_ph <= 0; end
                default: m_ph <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic rd_exp;
            rd_exp = (m_ph == 12) || (m_ph == 13);
            chk(busy_o == (m_ph != 0), "R5", "busy", 32'(busy_o), 32'(m_ph != 0));
            chk(done_o == m_done, "R5", "done", 32'(done_o), 32'(m_done));
            chk(susp_o == m_susp, "R6", "susp", 32'(susp_o), 32'(m_susp));
            chk(count_o == m_cnt, "R3", "count", 32'(count_o), 32'(m_cnt));
            chk(wptr_o == m_pw, "R2", "wptr", 32'(wptr_o), 32'(m_pw));
            chk(vptr_o == m_pv, "R2", "vptr", 32'(vptr_o), 32'(m_pv));
            chk(sum_prod_o == {m_hi, m_lo}, "R4", "sum_prod", sum_prod_o, {m_hi, m_lo});
            chk(sum_wt_o == m_sw, "R4", "sum_wt", 32'(sum_wt_o), 32'(m_sw));
            chk(mem_rd_o == rd_exp, "R10", "mem_rd", 32'(mem_rd_o), 32'(rd_exp));
            if (rd_exp)
                chk(mem_addr_o == ((m_ph == 12) ? m_pw : m_pv), "R2", "mem_addr",
                    32'(mem_addr_o), 32'((m_ph == 12) ? m_pw : m_pv));
        end
    end

    // ---- independent golden sums ----
    function automatic logic [31:0] gold_prod(input int n, input logic [15:0] pw,
                                              input logic [15:0] pv, input logic [31:0] init);
        logic [31:0] s = init;
        for (int i = 0; i < n; i++) s = s + 32'(mem_byte(pw + 16'(i))) * 32'(mem_byte(pv + 16'(i)));
        return s;
    endfunction

    function automatic logic [15:0] gold_wt(input int n, input logic [15:0] pw, input logic [15:0] init);
        logic [15:0] s = init;
        for (int i = 0; i < n; i++) s = s + 16'(mem_byte(pw + 16'(i)));
        return s;
    endfunction

    task automatic go(input bit st, input bit rs, input logic [7:0] c,
                      input logic [15:0] pw, input logic [15:0] pv);
        count_i = c; wptr_i = pw; vptr_i = pv; start_i = st; resume_i = rs;
        @(negedge clk);
        start_i = 1'b0; resume_i = 1'b0;
    endtask

    task automatic wait_end(output int n);
        n = 1;
        while (!done_o && !susp_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        chk(!busy_o && !done_o && !susp_o, "R5", "reset flags", {busy_o, done_o, susp_o}, 0);
        chk(sum_prod_o == 0 && sum_wt_o == 0 && count_o == 0, "R4", "reset sums", sum_prod_o, 0);

        // R1 / R4 / R5: fresh start, count 3
        rsum_prod_i = 32'h1234_5678; rsum_wt_i = 16'h0404;
        go(1'b1, 1'b0, 8'd3, 16'h1000, 16'h2000);   // now in cycle 1
        for (int c = 1; c <= 4; c++) begin
            chk(!mem_rd_o, "R1", "no read in prep", 32'(mem_rd_o), 0);
            if (c == 4) chk(sum_prod_o == 0 && sum_wt_o == 0, "R1", "sums cleared", sum_prod_o, 0);
            @(negedge clk);
        end
        chk(mem_rd_o && mem_addr_o == 16'h1000, "R1", "first read", 32'(mem_addr_o), 32'h1000);
        wait_end(n);
        chk(done_o, "R5", "done pulse", 32'(done_o), 1);
        chk(sum_prod_o == gold_prod(3, 16'h1000, 16'h2000, 0), "R4", "product sum",
            sum_prod_o, gold_prod(3, 16'h1000, 16'h2000, 0));
        chk(sum_wt_o == gold_wt(3, 16'h1000, 0), "R4", "weight sum", 32'(sum_wt_o),
            32'(gold_wt(3, 16'h1000, 0)));
        @(negedge clk);
        chk(!done_o, "R5", "done single cycle", 32'(done_o), 0);

        // R3: zero count wraps to 256 iterations, all-ones data forces carries
        mem_mode = 1;
        go(1'b1, 1'b0, 8'd0, 16'h3000, 16'h4000);
        repeat (4) @(negedge clk);
        chk(count_o == 8'd255, "R3", "count wraps", 32'(count_o), 255);
        wait_end(n);
        chk(done_o && sum_prod_o == 32'd16646400, "R3", "256 iterations product", sum_prod_o, 32'd16646400);
        chk(sum_wt_o == 16'd65280, "R3", "256 iterations weight", 32'(sum_wt_o), 32'd65280);
        chk(wptr_o == 16'h3100 && vptr_o == 16'h4100, "R2", "pointers +256", 32'(wptr_o), 32'h3100);
        mem_mode = 0;
        @(negedge clk);

        // R6 / R8: interrupt raised in the weight-sum cycle of iteration 1
        go(1'b1, 1'b0, 8'd4, 16'h0100, 16'h0200);
        n = 1;
        while (!susp_o && !done_o && n < 100) begin
            if (n == 7) irq_i = 1'b1;
            @(negedge clk);
            n++;
        end
        chk(susp_o && n == 18, "R8", "worst latency suspend cycle", n, 18);
        chk(count_o == 8'd3 && wptr_o == 16'h0101 && vptr_o == 16'h0201, "R6", "rewound state",
            {count_o, wptr_o[7:0], vptr_o[7:0]}, {8'd3, 8'h01, 8'h01});
        chk(sum_prod_o == gold_prod(1, 16'h0100, 16'h0200, 0), "R6", "partial sum",
            sum_prod_o, gold_prod(1, 16'h0100, 16'h0200, 0));

        // R7: resume with irq still pending; first iteration must complete
        rsum_prod_i = sum_prod_o; rsum_wt_i = sum_wt_o;
        @(negedge clk);
        go(1'b0, 1'b1, count_o, wptr_o, vptr_o);
        wait_end(n);
        chk(susp_o && n == 15, "R7", "resume suspend cycle", n, 15);
        chk(count_o == 8'd2 && sum_wt_o == gold_wt(2, 16'h0100, 0), "R7", "resumed progress",
            {count_o, sum_wt_o}, {8'd2, gold_wt(2, 16'h0100, 0)});
        irq_i = 1'b0;
        rsum_prod_i = sum_prod_o; rsum_wt_i = sum_wt_o;
        @(negedge clk);
        go(1'b0, 1'b1, count_o, wptr_o, vptr_o);
        wait_end(n);
        chk(done_o && sum_prod_o == gold_prod(4, 16'h0100, 16'h0200, 0), "R7", "resumed result",
            sum_prod_o, gold_prod(4, 16'h0100, 16'h0200, 0));

        // R9: start/resume while busy are ignored; start wins over resume
        @(negedge clk);
        go(1'b1, 1'b0, 8'd2, 16'h0500, 16'h0600);
        go(1'b1, 1'b1, 8'd9, 16'h0900, 16'h0A00);
        wait_end(n);
        chk(done_o && sum_prod_o == gold_prod(2, 16'h0500, 16'h0600, 0), "R9", "busy requests ignored",
            sum_prod_o, gold_prod(2, 16'h0500, 16'h0600, 0));
        @(negedge clk);
        rsum_prod_i = 32'h0000_7777; rsum_wt_i = 16'h0077;
        go(1'b1, 1'b1, 8'd1, 16'h0700, 16'h0800);
        wait_end(n);
        chk(done_o && sum_prod_o == gold_prod(1, 16'h0700, 16'h0800, 0), "R9", "start beats resume",
            sum_prod_o, gold_prod(1, 16'h0700, 16'h0800, 0));

        // R4: carry from a resumed low half near its limit
        @(negedge clk);
        rsum_prod_i = 32'h0001_FFF0; rsum_wt_i = 16'h0010;
        go(1'b0, 1'b1, 8'd1, 16'h00A0, 16'h00B0);
        wait_end(n);
        chk(done_o && sum_prod_o == gold_prod(1, 16'h00A0, 16'h00B0, 32'h0001_FFF0), "R4", "carry to high half",
            sum_prod_o, gold_prod(1, 16'h00A0, 16'h00B0, 32'h0001_FFF0));

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule